// File: doc/BRIEF.md
# Typed Record Table Walker

The walker searches a packed table of variable-length records held in a byte-wide memory. Each record opens with a formatted area. Byte 0 of that area is the record type, byte 1 is the formatted length, and bytes 2 and 3 hold a 16-bit handle. A string area follows the formatted area. The string area ends with two consecutive zero bytes. The walker moves from record to record and counts records whose type equals the requested one. It returns the start address of the match chosen by a copy index.

A host loads the table base, the table length in bytes, the requested type and the copy index, then pulses `start`. The walker issues single-byte reads, and each read has one cycle of latency. It then reports one of three results with a one-cycle `done` pulse:
- a record was found, with its address;
- the table ran out before the wanted match was reached;
- the table is malformed.

Finding the table and decoding the fields of a record are left to other logic.

Top module: `rtw_walker`

## Requirements
- R1: While reset is held and right after it is released, `busy`, `done`, `found`, `malformed` and `mem_rd` are all low.
- R2: After `start` is accepted, the first record is taken to begin at `tbl_base`. Every read places a byte address on `mem_addr` with `mem_rd` high, and the byte appears on `mem_data` in the next cycle.
- R3: The type is the byte at record offset 0 and the formatted length is the byte at offset 1. With copy index 0, the walker reports `found` for the first record whose type equals `want_type`, and `rec_addr` is that record's first byte.
- R4: With copy index N, each matching record passed over uses up one count, and the (N+1)th matching record is reported. Records of other types use up no count.
- R5: The next record begins after the formatted area, then after the string bytes up to the first pair of consecutive zero bytes, then two bytes past that pair. Zero bytes inside the formatted area and single zero bytes inside the strings do not end a record.
- R6: When the next record would begin at or beyond `tbl_base + tbl_len`, the walk ends with `done`, `found` low and `malformed` low. A table length of 0 ends this way at once, with no read.
- R7: A formatted length below 4, or a 4-byte header that does not fit below the table end, ends the walk with `malformed` high and `found` low.
- R8: A string area that reaches the table end without a double zero ends the walk as not-found, and no byte at or past the table end is read.
- R9: `done` is high for exactly one cycle per walk. `found`, `malformed` and `rec_addr` hold their values until the next accepted `start`. A `start` that arrives while `busy` is high is ignored.
- R10: `mem_rd` is high only while `busy` is high, and every address read lies in [`tbl_base`, `tbl_base + tbl_len`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a walk; sampled only while idle |
| tbl_base | input | AW | Byte address of the first record |
| tbl_len | input | AW | Table length in bytes |
| want_type | input | 8 | Record type to look for |
| want_copy | input | CW | Copy index of the wanted match (0 = first) |
| mem_rd | output | 1 | Byte read request |
| mem_addr | output | AW | Byte read address |
| mem_data | input | 8 | Read data, valid one cycle after the request |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse at the end of a walk |
| found | output | 1 | The last walk found the requested record |
| malformed | output | 1 | The last walk hit a malformed record |
| rec_addr | output | AW | Start address of the found record |

## Verification
The assertions check the properties that hold on every cycle:
- every read stays inside the table window captured at `start`;
- reads happen only during a walk;
- `done` is a single-cycle pulse;
- `found` and `malformed` never rise together;
- a reported address lies inside the table;
- results stay put while the walker is idle.

Only the bench scenarios can show that the walk lands on the right record. These scenarios cover zero bytes inside formatted areas and strings, copy counting across mixed types, the exact table-end boundary, truncated and short headers, unterminated strings, and a `start` issued mid-walk.

// File: rtl/rtw_pkg.sv
// Shared definitions for the record table walker.
// Assumes: records start with a 4-byte formatted header (type, length, handle).
package rtw_pkg;
    // Walk sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHK,
        ST_TYPE_RQ,
        ST_TYPE_WT,
        ST_LEN_WT,
        ST_S0_RQ,
        ST_S0_WT,
        ST_S1_WT
    } walk_state_t;

    // Smallest legal formatted area, in bytes
    localparam int unsigned HDR_BYTES = 4;
endpackage

// File: rtl/rtw_span.sv
// Table window: registers the exclusive end address at start and compares
// the sequencer's record and scan pointers against it.
// Assumes: pointers are one bit wider than the byte address, so base+len
// never wraps.
module rtw_span #(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] len,
    input  logic [AW:0]   cur,
    input  logic [AW:0]   pos,
    output logic          cur_at_end,
    output logic          hdr_short,
    output logic          scan_at_end,
    output logic          scan_next_at_end
);
    import rtw_pkg::*;
    localparam int unsigned EW = AW + 1;

    logic [EW-1:0] end_q;

    // Capture the exclusive table end when a walk begins
    always_ff @(posedge clk) begin
        if (!rst_n) end_q <= '0;
        else if (load) end_q <= EW'(base) + EW'(len);
    end

    // Boundary comparisons used by the sequencer
    always_comb begin
        cur_at_end       = cur >= end_q;
        hdr_short        = (cur + EW'(HDR_BYTES)) > end_q;
        scan_at_end      = (pos + EW'(1)) >= end_q;
        scan_next_at_end = (pos + EW'(2)) >= end_q;
    end
endmodule

// File: rtl/rtw_copy_ctr.sv
// Copy index counter: loaded at start, decremented once per passed-over
// matching record, flags when the current match is the wanted one.
// Assumes: load and dec are never high in the same cycle.
module rtw_copy_ctr #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] value,
    input  logic          dec,
    output logic          zero
);
    logic [CW-1:0] cnt_q;

    // Hold the remaining number of matches to skip
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt_q <= '0;
        else if (load) cnt_q <= value;
        else if (dec)  cnt_q <= cnt_q - CW'(1);
    end

    // Wanted match reached when nothing remains to skip
    assign zero = (cnt_q == '0);
endmodule

// File: rtl/rtw_seq.sv
// Walk sequencer: reads each record header, decides match / malformed,
// skips the formatted area and scans the string area for a double zero.
// Assumes: byte memory with one-cycle read latency; boundary flags and
// copy-counter status come from neighbouring blocks.
module rtw_seq #(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] tbl_base,
    input  logic [7:0]    want_type,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    input  logic [7:0]    mem_data,
    output logic [AW:0]   cur,
    output logic [AW:0]   pos,
    output logic          win_load,
    input  logic          cur_at_end,
    input  logic          hdr_short,
    input  logic          scan_at_end,
    input  logic          scan_next_at_end,
    output logic          cnt_load,
    output logic          cnt_dec,
    input  logic          cnt_zero,
    output logic          busy,
    output logic          done,
    output logic          found,
    output logic          malformed,
    output logic [AW-1:0] rec_addr
);
    import rtw_pkg::*;
    localparam int unsigned EW = AW + 1;

    walk_state_t   state_q;
    logic [EW-1:0] cur_q, pos_q, rd_addr;
    logic [7:0]    typ_q, want_q, b0_q;
    logic          done_q, found_q, bad_q;
    logic [AW-1:0] rec_q;
    logic          accept, len_bad, type_hit, pair_zero;

    assign accept    = (state_q == ST_IDLE) && start;
    assign len_bad   = mem_data < 8'(HDR_BYTES);
    assign type_hit  = typ_q == want_q;
    assign pair_zero = (b0_q == 8'h00) && (mem_data == 8'h00);

    // Read request for the byte the next state needs
    always_comb begin
        mem_rd  = 1'b0;
        rd_addr = cur_q;
        unique case (state_q)
            ST_TYPE_RQ: begin mem_rd = 1'b1; rd_addr = cur_q; end
            ST_TYPE_WT: begin mem_rd = 1'b1; rd_addr = cur_q + EW'(1); end
            ST_S0_RQ:   begin mem_rd = !scan_at_end; rd_addr = pos_q; end
            ST_S0_WT:   begin mem_rd = 1'b1; rd_addr = pos_q + EW'(1); end
            ST_S1_WT:   begin
                mem_rd  = !pair_zero && !scan_next_at_end;
                rd_addr = pos_q + EW'(2);
            end
            default: ;
        endcase
    end
    assign mem_addr = rd_addr[AW-1:0];

    // Neighbour control strobes
    assign win_load = accept;
    assign cnt_load = accept;
    assign cnt_dec  = (state_q == ST_LEN_WT) && !len_bad && type_hit && !cnt_zero;

    // Walk state, pointers and results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            pos_q   <= '0;
            typ_q   <= '0;
            want_q  <= '0;
            b0_q    <= '0;
            done_q  <= 1'b0;
            found_q <= 1'b0;
            bad_q   <= 1'b0;
            rec_q   <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start) begin
                    cur_q   <= EW'(tbl_base);
                    want_q  <= want_type;
                    found_q <= 1'b0;
                    bad_q   <= 1'b0;
                    state_q <= ST_CHK;
                end
                ST_CHK: begin
                    if (cur_at_end) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (hdr_short) begin
                        bad_q   <= 1'b1;
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_TYPE_RQ;
                    end
                end
                ST_TYPE_RQ: state_q <= ST_TYPE_WT;
                ST_TYPE_WT: begin
                    typ_q   <= mem_data;
                    state_q <= ST_LEN_WT;
                end
                ST_LEN_WT: begin
                    if (len_bad) begin
                        bad_q   <= 1'b1;
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (type_hit && cnt_zero) begin
                        found_q <= 1'b1;
                        rec_q   <= cur_q[AW-1:0];
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        pos_q   <= cur_q + EW'(mem_data);
                        state_q <= ST_S0_RQ;
                    end
                end
                ST_S0_RQ: begin
                    if (scan_at_end) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_S0_WT;
                    end
                end
                ST_S0_WT: begin
                    b0_q    <= mem_data;
                    state_q <= ST_S1_WT;
                end
                ST_S1_WT: begin
                    if (pair_zero) begin
                        cur_q   <= pos_q + EW'(2);
                        state_q <= ST_CHK;
                    end else if (scan_next_at_end) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        pos_q <= pos_q + EW'(1);
                        b0_q  <= mem_data;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cur       = cur_q;
    assign pos       = pos_q;
    assign busy      = state_q != ST_IDLE;
    assign done      = done_q;
    assign found     = found_q;
    assign malformed = bad_q;
    assign rec_addr  = rec_q;
endmodule

// File: rtl/rtw_walker.sv
// Typed record table walker top: joins the sequencer, the table window and
// the copy counter.
// Assumes: byte-wide memory with one-cycle read latency; inputs are stable
// while start is high.
module rtw_walker #(
    parameter int unsigned AW = 16,
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] tbl_base,
    input  logic [AW-1:0] tbl_len,
    input  logic [7:0]    want_type,
    input  logic [CW-1:0] want_copy,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    input  logic [7:0]    mem_data,
    output logic          busy,
    output logic          done,
    output logic          found,
    output logic          malformed,
    output logic [AW-1:0] rec_addr
);
    logic [AW:0] cur, pos;
    logic win_load, cur_at_end, hdr_short, scan_at_end, scan_next_at_end;
    logic cnt_load, cnt_dec, cnt_zero;

    rtw_seq #(.AW(AW)) i_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .tbl_base(tbl_base),
        .want_type(want_type), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_data(mem_data), .cur(cur), .pos(pos), .win_load(win_load),
        .cur_at_end(cur_at_end), .hdr_short(hdr_short),
        .scan_at_end(scan_at_end), .scan_next_at_end(scan_next_at_end),
        .cnt_load(cnt_load), .cnt_dec(cnt_dec), .cnt_zero(cnt_zero),
        .busy(busy), .done(done), .found(found), .malformed(malformed),
        .rec_addr(rec_addr)
    );

    rtw_span #(.AW(AW)) i_span (
        .clk(clk), .rst_n(rst_n), .load(win_load), .base(tbl_base),
        .len(tbl_len), .cur(cur), .pos(pos), .cur_at_end(cur_at_end),
        .hdr_short(hdr_short), .scan_at_end(scan_at_end),
        .scan_next_at_end(scan_next_at_end)
    );

    rtw_copy_ctr #(.CW(CW)) i_copy (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .value(want_copy),
        .dec(cnt_dec), .zero(cnt_zero)
    );
endmodule

// File: rtl/rtw_chk.sv
// Assertion checker for the walker; records the table window at each
// accepted start and checks reads and results against it.
module rtw_chk #(
    parameter int unsigned AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [AW-1:0] tbl_base,
    input logic [AW-1:0] tbl_len,
    input logic          mem_rd,
    input logic [AW-1:0] mem_addr,
    input logic          busy,
    input logic          done,
    input logic          found,
    input logic          malformed,
    input logic [AW-1:0] rec_addr
);
    logic [AW:0] lo_q, hi_q;

    // Shadow copy of the table window of the current walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (!busy && start) begin
            lo_q <= (AW+1)'(tbl_base);
            hi_q <= (AW+1)'(tbl_base) + (AW+1)'(tbl_len);
        end
    end

    p_rd_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> ((AW+1)'(mem_addr) >= lo_q) && ((AW+1)'(mem_addr) < hi_q));
    p_rd_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> busy);
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_result_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(found && malformed));
    p_found_in_table_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found) |-> ((AW+1)'(rec_addr) >= lo_q) && ((AW+1)'(rec_addr) < hi_q));
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(found) && $stable(malformed) && $stable(rec_addr) && !busy));
endmodule

bind rtw_walker rtw_chk #(.AW(AW)) i_rtw_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .tbl_base(tbl_base),
    .tbl_len(tbl_len), .mem_rd(mem_rd), .mem_addr(mem_addr), .busy(busy),
    .done(done), .found(found), .malformed(malformed), .rec_addr(rec_addr)
);

// File: tb/test_rtw_walker.sv
module test_rtw_walker;
    localparam int AW = 16;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] tbl_base = '0;
    logic [AW-1:0] tbl_len = '0;
    logic [7:0]    want_type = '0;
    logic [CW-1:0] want_copy = '0;
    logic          mem_rd;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_data = '0;
    logic          busy, done, found, malformed;
    logic [AW-1:0] rec_addr;

    int checks = 0;
    int failures = 0;
    int oob = 0;
    int cyc = 0;
    logic [AW:0] win_lo = '0, win_hi = '0;
    logic [7:0] mem [0:511];

    always #4 clk = ~clk;

    rtw_walker #(.AW(AW), .CW(CW)) i_rtw_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .tbl_base(tbl_base),
        .tbl_len(tbl_len), .want_type(want_type), .want_copy(want_copy),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_data(mem_data),
        .busy(busy), .done(done), .found(found), .malformed(malformed),
        .rec_addr(rec_addr)
    );

    // Byte memory, one cycle latency
    always_ff @(posedge clk) if (mem_rd) mem_data <= mem[mem_addr[8:0]];

    // Read window monitor (R10)
    always @(negedge clk) if (rst_n && mem_rd &&
        (({1'b0, mem_addr} < win_lo) || ({1'b0, mem_addr} >= win_hi) || !busy)) oob++;

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++; failures++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
            summary();
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(int a, logic [7:0] v);
        mem[a] = v;
    endtask

    task automatic pulse_start(int base, int len, int typ, int copy);
        tbl_base = AW'(base); tbl_len = AW'(len);
        want_type = 8'(typ); want_copy = CW'(copy);
        if (!busy) begin
            win_lo = (AW+1)'(base);
            win_hi = (AW+1)'(base + len);
        end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 2000) begin @(negedge clk); n++; end
        chk("R9 done seen", 32'(done), 32'd1);
    endtask

    task automatic query(string req, int base, int len, int typ, int copy,
                         logic exp_f, logic exp_m, int exp_a);
        pulse_start(base, len, typ, copy);
        wait_done();
        chk({req, " found"}, 32'(found), 32'(exp_f));
        chk({req, " malformed"}, 32'(malformed), 32'(exp_m));
        if (exp_f) chk({req, " rec_addr"}, 32'(rec_addr), 32'(exp_a));
        @(negedge clk);
    endtask

    task automatic build_tables();
        for (int i = 0; i < 512; i++) mem[i] = 8'hEE;
        // rec @0x40: type 1, len 4, strings "ab"
        put(9'h40, 8'd1); put(9'h41, 8'd4); put(9'h42, 8'h11); put(9'h43, 8'h22);
        put(9'h44, "a"); put(9'h45, "b"); put(9'h46, 8'h00); put(9'h47, 8'h00);
        // rec @0x48: type 212, len 6 with zero formatted bytes, string "x"
        put(9'h48, 8'd212); put(9'h49, 8'd6); put(9'h4A, 8'h34); put(9'h4B, 8'h12);
        put(9'h4C, 8'h00); put(9'h4D, 8'h00); put(9'h4E, "x"); put(9'h4F, 8'h00);
        put(9'h50, 8'h00);
        // rec @0x51: type 1, len 5, strings "a","b"
        put(9'h51, 8'd1); put(9'h52, 8'd5); put(9'h53, 8'h00); put(9'h54, 8'h00);
        put(9'h55, 8'h00); put(9'h56, "a"); put(9'h57, 8'h00); put(9'h58, "b");
        put(9'h59, 8'h00); put(9'h5A, 8'h00);
        // rec @0x5B: type 212, len 4, empty strings; table ends at 0x61
        put(9'h5B, 8'd212); put(9'h5C, 8'd4); put(9'h5D, 8'h01); put(9'h5E, 8'h02);
        put(9'h5F, 8'h00); put(9'h60, 8'h00);
        // short formatted length at 0x100
        put(9'h100, 8'd2); put(9'h101, 8'd3); put(9'h102, 8'h00); put(9'h103, 8'h00);
        // unterminated strings at 0x120, table length 10
        put(9'h120, 8'd5); put(9'h121, 8'd4); put(9'h122, 8'h07); put(9'h123, 8'h08);
        for (int i = 0; i < 6; i++) put(9'h124 + i, 8'h61 + 8'(i));
    endtask

    task automatic t_reset();
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 found", 32'(found), 32'd0);
        chk("R1 malformed", 32'(malformed), 32'(0));
        chk("R1 mem_rd", 32'(mem_rd), 32'd0);
    endtask

    task automatic t_first_match();
        query("R2 R3 type1 copy0", 9'h40, 33, 1, 0, 1'b1, 1'b0, 9'h40);
        query("R3 R5 type212 copy0", 9'h40, 33, 212, 0, 1'b1, 1'b0, 9'h48);
    endtask

    task automatic t_copy_index();
        query("R4 R5 type1 copy1", 9'h40, 33, 1, 1, 1'b1, 1'b0, 9'h51);
        query("R4 type212 copy1", 9'h40, 33, 212, 1, 1'b1, 1'b0, 9'h5B);
    endtask

    task automatic t_table_end();
        query("R6 type1 copy2 past end", 9'h40, 33, 1, 2, 1'b0, 1'b0, 0);
        query("R6 absent type", 9'h40, 33, 7, 0, 1'b0, 1'b0, 0);
        query("R6 zero length", 9'h40, 0, 1, 0, 1'b0, 1'b0, 0);
    endtask

    task automatic t_malformed();
        query("R7 length below 4", 9'h100, 8, 2, 0, 1'b0, 1'b1, 0);
        query("R7 truncated header", 9'h100, 3, 2, 0, 1'b0, 1'b1, 0);
    endtask

    task automatic t_unterminated();
        query("R8 found before scan", 9'h120, 10, 5, 0, 1'b1, 1'b0, 9'h120);
        query("R8 unterminated strings", 9'h120, 10, 5, 1, 1'b0, 1'b0, 0);
    endtask

    task automatic t_pulse_hold();
        pulse_start(9'h40, 33, 212, 1);
        wait_done();
        @(negedge clk);
        chk("R9 done one cycle", 32'(done), 32'd0);
        repeat (5) @(negedge clk);
        chk("R9 found held", 32'(found), 32'd1);
        chk("R9 rec_addr held", 32'(rec_addr), 32'h5B);
    endtask

    task automatic t_start_while_busy();
        pulse_start(9'h40, 33, 1, 1);
        repeat (3) @(negedge clk);
        chk("R9 busy mid walk", 32'(busy), 32'd1);
        pulse_start(9'h40, 33, 212, 0);
        wait_done();
        chk("R9 ignored start found", 32'(found), 32'd1);
        chk("R9 ignored start rec_addr", 32'(rec_addr), 32'h51);
        @(negedge clk);
    endtask

    initial begin
        build_tables();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_match();
        t_copy_index();
        t_table_end();
        t_malformed();
        t_unterminated();
        t_pulse_hold();
        t_start_while_busy();
        chk("R10 reads inside window", 32'(oob), 32'd0);
        summary();
    end
endmodule